// File: doc/BRIEF.md
# Partial reconfiguration control engine

This engine sits between a host register bus and a configuration consumer and carries a reconfiguration image into the fabric one 32-bit word at a time. Software first pulses an engine reset through a control register and waits for the acknowledge. It then opens a session that targets one of eight regions and streams image words through a data register, pacing itself by the free-entry count shown in the status register. Finally it signals that the push is finished and polls until hardware drops the session bit.

Words wait in an internal queue and leave through a valid/ready stream. Each word carries the region tag that was latched when the session opened, and the last word of an image is marked. A stub consumer's error inputs are sampled on that last word. Faults are held in sticky flags that software clears by writing ones. A fixed 128-bit interface identifier, set at build time and shared by all regions, lets software check that an image suits the engine.

Top module: `pr_ctrl_engine`

## Requirements
- R1: Register offsets are control 0x08, status 0x10, data 0x18, error 0x20, identifier upper 64 bits 0xA8 and lower 64 bits 0xB0. The identifier equals the IFACE_ID parameter, and writes to it have no effect. After reset, control and error read 0.
- R2: Writing control bit 0 = 1 puts the engine in reset. From the next cycle, and for as long as the bit stays set, control bit 4 (acknowledge) reads 1, the queue is flushed and any session is abandoned. Writing bit 0 = 0 returns the engine to idle, with control reading 0 and full credits.
- R3: A control write with bit 12 = 1 (and bit 0 = 0) while idle opens a session and latches the region in bits 9:7. While a session is open, control bit 12 reads 1, writes to bits 9:7 are ignored, and cfg_region stays at the latched value.
- R4: During an open session, each write to the data register queues its bits 31:0 as one word. Words leave on cfg_data in write order, tagged with the session region.
- R5: Status bits 8:0 give the free queue entries, which equal DEPTH minus the queued words. The count updates in the cycle after a push or a pop.
- R6: A data write while the free count is 0 is dropped and sets error bit 4 (overflow).
- R7: A data write made with no session accepting data (idle, reset, or after completion was signalled) is dropped and sets error bit 3 (protocol).
- R8: Writing control bit 13 = 1 during a session marks the push complete, and control bit 13 then reads 1. The engine drains the remaining words, raises cfg_last on the final word still queued, then clears control bits 12 and 13 by itself. If the queue is already empty, the session closes without a last word.
- R9: On the handshake of the last word, sink_op_err, sink_crc_err and sink_incompat_err set error bits 0, 1 and 2 respectively.
- R10: Writing the error register clears exactly the flags written as 1 and leaves the others; a flag being set in the same cycle wins. Flags otherwise stay set.
- R11: Status bit 16 reads 1 while a session is open or any error flag is set, else 0. Bits 22:20 give the controller state: 0 idle, 1 reset, 2 accepting, 3 draining. Bits 27:24 give the host view: bit 24 accepting data, bit 25 queue empty, bit 26 queue full, bit 27 error pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 8 | Register write byte offset |
| reg_wr_data | input | 64 | Register write data |
| reg_rd_addr | input | 8 | Register read byte offset |
| reg_rd_data | output | 64 | Register read data, combinational from reg_rd_addr |
| cfg_valid | output | 1 | Image word available |
| cfg_ready | input | 1 | Consumer accepts the word |
| cfg_data | output | 32 | Image word |
| cfg_region | output | 3 | Target region of the session |
| cfg_last | output | 1 | Final word of the image |
| sink_op_err | input | 1 | Consumer operation fault, sampled on the last word |
| sink_crc_err | input | 1 | Consumer CRC fault, sampled on the last word |
| sink_incompat_err | input | 1 | Consumer incompatible-image fault, sampled on the last word |

## Verification
The assertions check on every cycle that the acknowledge state holds while reset is requested and that the region tag stays put during a session. They also check that the stream is quiet outside a session, that the queue count never exceeds its depth, that a last-word handshake ends the session, that overflow and protocol writes raise their flags, and that flags only fall when written with ones. The bench scenarios cover what needs a whole sequence to show. These are word order through the queue under stalled and alternating back-pressure, the credit count after a run of pushes, and a drop at full credit that leaves no trace on the stream. They also cover the difference between completing with words queued and completing on an empty queue, a reset that discards a partly pushed image, and sink faults that persist after the session closes until selectively cleared.

// File: rtl/pr_eng_pkg.sv
package pr_eng_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RESET  = 3'd1,
    ST_ACTIVE = 3'd2,
    ST_DRAIN  = 3'd3
  } pr_state_e;

  localparam logic [7:0] OFS_CTL   = 8'h08;
  localparam logic [7:0] OFS_STS   = 8'h10;
  localparam logic [7:0] OFS_DATA  = 8'h18;
  localparam logic [7:0] OFS_ERR   = 8'h20;
  localparam logic [7:0] OFS_ID_HI = 8'hA8;
  localparam logic [7:0] OFS_ID_LO = 8'hB0;

  localparam int CB_RST   = 0;
  localparam int CB_ACK   = 4;
  localparam int CB_RGN_L = 7;
  localparam int CB_START = 12;
  localparam int CB_DONE  = 13;

  localparam int EB_OPER     = 0;
  localparam int EB_CRC      = 1;
  localparam int EB_INCOMPAT = 2;
  localparam int EB_PROTO    = 3;
  localparam int EB_OVFL     = 4;
  localparam int NERR        = 5;

  localparam int RGN_W    = 3;
  localparam int WORD_W   = 32;
  localparam int CREDIT_W = 9;

endpackage

// File: rtl/pr_word_queue.sv
module pr_word_queue #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 32,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head_data,
  output logic [CW-1:0]    count,
  output logic             empty,
  output logic             full,
  output logic             one_left
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr_q, wr_ptr_nx;
  logic [AW-1:0]    rd_ptr_q, rd_ptr_nx;
  logic [CW-1:0]    cnt_q, cnt_nx;
  logic             do_push, do_pop;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign empty    = (cnt_q == '0);
  assign full     = (cnt_q == CW'(DEPTH));
  assign one_left = (cnt_q == CW'(1));
  assign count    = cnt_q;
  assign head_data = mem[rd_ptr_q];

  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;

  always_comb begin
    wr_ptr_nx = wr_ptr_q;
    rd_ptr_nx = rd_ptr_q;
    cnt_nx    = cnt_q;
    if (flush) begin
      wr_ptr_nx = '0;
      rd_ptr_nx = '0;
      cnt_nx    = '0;
    end else begin
      if (do_push) wr_ptr_nx = step(wr_ptr_q);
      if (do_pop)  rd_ptr_nx = step(rd_ptr_q);
      if (do_push && !do_pop)      cnt_nx = cnt_q + CW'(1);
      else if (do_pop && !do_push) cnt_nx = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_nx;
      rd_ptr_q <= rd_ptr_nx;
      cnt_q    <= cnt_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr_q] <= push_data;
  end

endmodule

// File: rtl/pr_session_fsm.sv
module pr_session_fsm
  import pr_eng_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      rst_req,
  input  logic      start_req,
  input  logic      done_req,
  input  logic      q_empty,
  input  logic      q_one,
  input  logic      pop,
  output pr_state_e state,
  output logic      last
);

  pr_state_e state_q, state_nx;

  assign state = state_q;
  assign last  = (state_q == ST_DRAIN) && q_one;

  always_comb begin
    state_nx = state_q;
    case (state_q)
      ST_IDLE:   if (start_req) state_nx = ST_ACTIVE;
      ST_ACTIVE: if (done_req) state_nx = ST_DRAIN;
      ST_DRAIN:  if (q_empty || (pop && last)) state_nx = ST_IDLE;
      ST_RESET:  if (!rst_req) state_nx = ST_IDLE;
      default:   state_nx = ST_IDLE;
    endcase
    if (rst_req) state_nx = ST_RESET;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_nx;
  end

endmodule

// File: rtl/pr_err_log.sv
module pr_err_log #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] flags
);

  logic [N-1:0] flags_q, flags_nx;

  assign flags = flags_q;

  always_comb begin
    flags_nx = (flags_q & ~clr_vec) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_nx;
  end

endmodule

// File: rtl/pr_ctrl_engine.sv
module pr_ctrl_engine
  import pr_eng_pkg::*;
#(
  parameter int           DEPTH    = 16,
  parameter logic [127:0] IFACE_ID = 128'h3a5f_0c21_9be4_7d60_c1a8_5e23_f04b_9d17,
  localparam int          CW       = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr_en,
  input  logic [7:0]          reg_wr_addr,
  input  logic [63:0]         reg_wr_data,
  input  logic [7:0]          reg_rd_addr,
  output logic [63:0]         reg_rd_data,
  output logic                cfg_valid,
  input  logic                cfg_ready,
  output logic [WORD_W-1:0]   cfg_data,
  output logic [RGN_W-1:0]    cfg_region,
  output logic                cfg_last,
  input  logic                sink_op_err,
  input  logic                sink_crc_err,
  input  logic                sink_incompat_err
);

  // DEPTH must stay at or below 511 so the credit field can hold it.

  logic              wr_ctl, wr_dat, wr_err;
  logic              ctl_rst_q, ctl_rst_nx;
  logic [RGN_W-1:0]  region_q, region_nx;
  logic              region_en;
  pr_state_e         state_q;
  logic              sess_open, in_session;
  logic              start_req, done_req;
  logic              q_push, q_pop, q_flush;
  logic              q_empty, q_full, q_one;
  logic [CW-1:0]     q_count;
  logic              last_w;
  logic [CREDIT_W-1:0] free_cnt;
  logic [NERR-1:0]   err_q, err_set, err_clr;
  logic [63:0]       ctl_view, sts_view, err_view;
  logic [3:0]        host_view;
  logic              unused_wr_bits;

  assign unused_wr_bits = ^{reg_wr_data[63:32]};

  // Register write decode
  assign wr_ctl = reg_wr_en && (reg_wr_addr == OFS_CTL);
  assign wr_dat = reg_wr_en && (reg_wr_addr == OFS_DATA);
  assign wr_err = reg_wr_en && (reg_wr_addr == OFS_ERR);

  assign sess_open  = (state_q == ST_ACTIVE);
  assign in_session = (state_q == ST_ACTIVE) || (state_q == ST_DRAIN);

  assign start_req = wr_ctl && reg_wr_data[CB_START] && !reg_wr_data[CB_RST] && !ctl_rst_q;
  assign done_req  = wr_ctl && reg_wr_data[CB_DONE];

  // Control register fields
  assign region_en = wr_ctl && !in_session;

  always_comb begin
    ctl_rst_nx = ctl_rst_q;
    region_nx  = region_q;
    if (wr_ctl)    ctl_rst_nx = reg_wr_data[CB_RST];
    if (region_en) region_nx  = reg_wr_data[CB_RGN_L +: RGN_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_rst_q <= 1'b0;
      region_q  <= '0;
    end else begin
      ctl_rst_q <= ctl_rst_nx;
      region_q  <= region_nx;
    end
  end

  // Session sequencing
  pr_session_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_req   (ctl_rst_q),
    .start_req (start_req),
    .done_req  (done_req),
    .q_empty   (q_empty),
    .q_one     (q_one),
    .pop       (q_pop),
    .state     (state_q),
    .last      (last_w)
  );

  // Word queue
  assign q_flush = (state_q == ST_RESET);
  assign q_push  = wr_dat && sess_open && !q_full;
  assign q_pop   = cfg_valid && cfg_ready;

  pr_word_queue #(
    .DEPTH (DEPTH),
    .WIDTH (WORD_W)
  ) u_queue (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (q_flush),
    .push      (q_push),
    .push_data (reg_wr_data[WORD_W-1:0]),
    .pop       (q_pop),
    .head_data (cfg_data),
    .count     (q_count),
    .empty     (q_empty),
    .full      (q_full),
    .one_left  (q_one)
  );

  assign cfg_valid  = in_session && !q_empty;
  assign cfg_last   = cfg_valid && last_w;
  assign cfg_region = region_q;

  assign free_cnt = CREDIT_W'(DEPTH) - CREDIT_W'(q_count);

  // Sticky error flags
  always_comb begin
    err_set              = '0;
    err_set[EB_OPER]     = q_pop && last_w && sink_op_err;
    err_set[EB_CRC]      = q_pop && last_w && sink_crc_err;
    err_set[EB_INCOMPAT] = q_pop && last_w && sink_incompat_err;
    err_set[EB_PROTO]    = wr_dat && !sess_open;
    err_set[EB_OVFL]     = wr_dat && sess_open && q_full;
    err_clr              = wr_err ? reg_wr_data[NERR-1:0] : '0;
  end

  pr_err_log #(.N(NERR)) u_err (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (err_set),
    .clr_vec (err_clr),
    .flags   (err_q)
  );

  // Read views
  assign host_view = {(err_q != '0), q_full, q_empty, sess_open};

  always_comb begin
    ctl_view                         = '0;
    ctl_view[CB_RST]                 = ctl_rst_q;
    ctl_view[CB_ACK]                 = (state_q == ST_RESET);
    ctl_view[CB_RGN_L +: RGN_W]      = region_q;
    ctl_view[CB_START]               = in_session;
    ctl_view[CB_DONE]                = (state_q == ST_DRAIN);

    sts_view                         = '0;
    sts_view[CREDIT_W-1:0]           = free_cnt;
    sts_view[16]                     = in_session || (err_q != '0);
    sts_view[22:20]                  = state_q;
    sts_view[27:24]                  = host_view;

    err_view                         = '0;
    err_view[NERR-1:0]               = err_q;
  end

  always_comb begin
    case (reg_rd_addr)
      OFS_CTL:   reg_rd_data = ctl_view;
      OFS_STS:   reg_rd_data = sts_view;
      OFS_ERR:   reg_rd_data = err_view;
      OFS_ID_HI: reg_rd_data = IFACE_ID[127:64];
      OFS_ID_LO: reg_rd_data = IFACE_ID[63:0];
      default:   reg_rd_data = '0;
    endcase
  end

endmodule

// File: rtl/pr_ctrl_engine_chk.sv
module pr_ctrl_engine_chk
  import pr_eng_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr_en,
  input logic [7:0]  reg_wr_addr,
  input logic [63:0] reg_wr_data,
  input logic        cfg_valid,
  input logic        cfg_ready,
  input logic        cfg_last,
  input logic [2:0]  cfg_region,
  input logic        ctl_rst,
  input logic [2:0]  state,
  input logic [4:0]  err,
  input logic [CW-1:0] q_count
);

  logic       sess;
  logic       dat_wr;
  logic [4:0] clr_now;

  assign sess    = (state == ST_ACTIVE) || (state == ST_DRAIN);
  assign dat_wr  = reg_wr_en && (reg_wr_addr == OFS_DATA);
  assign clr_now = (reg_wr_en && (reg_wr_addr == OFS_ERR)) ? reg_wr_data[4:0] : 5'd0;

  p_ack_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rst && $past(ctl_rst)) |-> (state == ST_RESET));

  p_region_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sess && $past(sess)) |-> $stable(cfg_region));

  p_stream_in_session_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> sess);

  p_credit_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= CW'(DEPTH));

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && state == ST_ACTIVE && q_count == CW'(DEPTH)) |=> err[EB_OVFL]);

  p_protocol_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && state != ST_ACTIVE) |=> err[EB_PROTO]);

  p_last_closes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && cfg_ready && cfg_last) |=> !sess);

  p_sticky_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(err) & ~$past(clr_now) & ~err) == 5'd0));

endmodule

bind pr_ctrl_engine pr_ctrl_engine_chk #(.DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_wr_en   (reg_wr_en),
  .reg_wr_addr (reg_wr_addr),
  .reg_wr_data (reg_wr_data),
  .cfg_valid   (cfg_valid),
  .cfg_ready   (cfg_ready),
  .cfg_last    (cfg_last),
  .cfg_region  (cfg_region),
  .ctl_rst     (ctl_rst_q),
  .state       (state_q),
  .err         (err_q),
  .q_count     (q_count)
);

// File: tb/pr_ctrl_engine_tb.sv
module pr_ctrl_engine_tb;

  localparam int DEPTH = 8;
  localparam logic [127:0] ID = 128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210;

  logic        clk, rst_n;
  logic        reg_wr_en;
  logic [7:0]  reg_wr_addr, reg_rd_addr;
  logic [63:0] reg_wr_data, reg_rd_data;
  logic        cfg_valid, cfg_ready, cfg_last;
  logic [31:0] cfg_data;
  logic [2:0]  cfg_region;
  logic        sink_op_err, sink_crc_err, sink_incompat_err;

  typedef struct packed { logic [31:0] d; logic [2:0] r; logic l; } item_t;
  item_t exp_q[$];

  int n_chk = 0, n_bad = 0;
  int ready_mode = 0; // 0 hold low, 1 always high, 2 alternate

  pr_ctrl_engine #(.DEPTH(DEPTH), .IFACE_ID(ID)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
    .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_data(cfg_data),
    .cfg_region(cfg_region), .cfg_last(cfg_last),
    .sink_op_err(sink_op_err), .sink_crc_err(sink_crc_err),
    .sink_incompat_err(sink_incompat_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] sts(input int free, input bit op, input int st, input int host);
    return (64'(host) << 24) | (64'(st) << 20) | (64'(op) << 16) | 64'(free);
  endfunction

  task automatic wr(input logic [7:0] a, input logic [63:0] d);
    @(posedge clk); #1;
    reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
    @(posedge clk); #1;
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [63:0] d);
    @(posedge clk); #1;
    reg_rd_addr = a;
    #2 d = reg_rd_data;
  endtask

  task automatic push(input logic [31:0] w, input logic [2:0] r, input bit expect_it);
    item_t it;
    it.d = w; it.r = r; it.l = 1'b0;
    if (expect_it) exp_q.push_back(it);
    wr(8'h18, {32'hdead_0000, w});
  endtask

  task automatic mark_last();
    item_t it;
    it = exp_q[exp_q.size()-1];
    it.l = 1'b1;
    exp_q[exp_q.size()-1] = it;
  endtask

  task automatic wait_start_low(input string req);
    logic [63:0] v;
    int k = 0;
    do begin
      rd(8'h08, v);
      k++;
    end while (v[12] && k < 300);
    chk(req, {63'd0, v[12]}, 64'd0);
  endtask

  // ready driver
  initial begin
    cfg_ready = 1'b0;
    forever begin
      @(posedge clk); #1;
      case (ready_mode)
        1:       cfg_ready = 1'b1;
        2:       cfg_ready = ~cfg_ready;
        default: cfg_ready = 1'b0;
      endcase
    end
  end

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && cfg_valid && cfg_ready) begin
        if (exp_q.size() == 0) begin
          chk("R4 unexpected word", {32'd0, cfg_data}, 64'hffff_ffff_ffff_ffff);
        end else begin
          item_t e;
          e = exp_q.pop_front();
          chk("R4 word data", {32'd0, cfg_data}, {32'd0, e.d});
          chk("R3 word region", {61'd0, cfg_region}, {61'd0, e.r});
          chk("R8 last marker", {63'd0, cfg_last}, {63'd0, e.l});
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] v;
    rst_n = 1'b0;
    reg_wr_en = 1'b0; reg_wr_addr = '0; reg_wr_data = '0; reg_rd_addr = '0;
    sink_op_err = 1'b0; sink_crc_err = 1'b0; sink_incompat_err = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state and map
    rd(8'h08, v); chk("R1 ctl after reset", v, 64'd0);
    rd(8'h20, v); chk("R1 err after reset", v, 64'd0);
    rd(8'h10, v); chk("R11 status after reset", v, sts(DEPTH, 0, 0, 4'b0010));
    rd(8'hA8, v); chk("R1 id upper", v, ID[127:64]);
    rd(8'hB0, v); chk("R1 id lower", v, ID[63:0]);
    wr(8'hA8, 64'h5555_5555_5555_5555);
    rd(8'hA8, v); chk("R1 id write ignored", v, ID[127:64]);

    // R7 protocol violation when no session
    push(32'h1111_0001, 3'd0, 0);
    rd(8'h20, v); chk("R7 proto flag", v, 64'h8);
    rd(8'h10, v); chk("R7 word dropped, op status set (R11)", v, sts(DEPTH, 1, 0, 4'b1010));
    wr(8'h20, 64'h8);
    rd(8'h20, v); chk("R10 clear proto", v, 64'd0);

    // Session A: R3 R4 R5 R8
    ready_mode = 0;
    wr(8'h08, (64'd1 << 12) | (64'd5 << 7));
    rd(8'h08, v); chk("R3 start and region", v, (64'd1 << 12) | (64'd5 << 7));
    rd(8'h10, v); chk("R11 status accepting", v, sts(DEPTH, 1, 2, 4'b0011));
    push(32'hA000_0001, 3'd5, 1);
    push(32'hA000_0002, 3'd5, 1);
    push(32'hA000_0003, 3'd5, 1);
    rd(8'h10, v); chk("R5 credits after 3 pushes", {55'd0, v[8:0]}, 64'(DEPTH - 3));
    wr(8'h08, (64'd1 << 12) | (64'd2 << 7));
    rd(8'h08, v); chk("R3 region change ignored", {61'd0, v[9:7]}, 64'd5);
    chk("R3 cfg_region held", {61'd0, cfg_region}, 64'd5);
    wr(8'h08, (64'd1 << 13) | (64'd1 << 12) | (64'd5 << 7));
    mark_last();
    rd(8'h08, v); chk("R8 complete bit reads 1", {63'd0, v[13]}, 64'd1);
    rd(8'h10, v); chk("R11 draining state", {61'd0, v[22:20]}, 64'd3);
    push(32'hBAD0_0000, 3'd5, 0);
    rd(8'h20, v); chk("R7 write after complete", v, 64'h8);
    wr(8'h20, 64'h8);
    ready_mode = 2;
    wait_start_low("R8 start self-clears after drain");
    rd(8'h10, v); chk("R11 idle after session", v, sts(DEPTH, 0, 0, 4'b0010));

    // R6 overflow
    ready_mode = 0;
    wr(8'h08, (64'd1 << 12) | (64'd1 << 7));
    for (int i = 0; i < DEPTH; i++) push(32'hC000_0000 + 32'(i), 3'd1, 1);
    rd(8'h10, v); chk("R5 credits zero when full", {55'd0, v[8:0]}, 64'd0);
    push(32'hBAD0_0001, 3'd1, 0);
    rd(8'h20, v); chk("R6 overflow flag", v, 64'h10);
    rd(8'h10, v); chk("R11 host view full+err", {60'd0, v[27:24]}, 64'b1101);
    wr(8'h08, (64'd1 << 13) | (64'd1 << 12) | (64'd1 << 7));
    mark_last();
    ready_mode = 1;
    wait_start_low("R8 drain after overflow");
    wr(8'h20, 64'h1f);
    rd(8'h20, v); chk("R10 clear all", v, 64'd0);

    // R9 sink errors sampled on last word
    ready_mode = 0;
    sink_crc_err = 1'b1;
    wr(8'h08, (64'd1 << 12) | (64'd6 << 7));
    push(32'hD000_0001, 3'd6, 1);
    push(32'hD000_0002, 3'd6, 1);
    rd(8'h20, v); chk("R9 no flag before last word", v, 64'd0);
    wr(8'h08, (64'd1 << 13) | (64'd1 << 12) | (64'd6 << 7));
    mark_last();
    ready_mode = 2;
    wait_start_low("R8 session ends");
    sink_crc_err = 1'b0;
    rd(8'h20, v); chk("R9 crc flag", v, 64'h2);
    rd(8'h10, v); chk("R11 op status held by error", v, sts(DEPTH, 1, 0, 4'b1010));
    wr(8'h20, 64'h0);
    rd(8'h20, v); chk("R10 write zero keeps flag", v, 64'h2);
    wr(8'h20, 64'h2);
    rd(8'h10, v); chk("R11 op status idle after clear", v, sts(DEPTH, 0, 0, 4'b0010));

    ready_mode = 0;
    sink_op_err = 1'b1; sink_incompat_err = 1'b1;
    wr(8'h08, (64'd1 << 12) | (64'd3 << 7));
    push(32'hE000_0001, 3'd3, 1);
    wr(8'h08, (64'd1 << 13) | (64'd1 << 12) | (64'd3 << 7));
    mark_last();
    ready_mode = 1;
    wait_start_low("R8 single word image");
    sink_op_err = 1'b0; sink_incompat_err = 1'b0;
    rd(8'h20, v); chk("R9 op and incompat flags", v, 64'h5);
    wr(8'h20, 64'h1);
    rd(8'h20, v); chk("R10 clears exactly bit 0", v, 64'h4);
    wr(8'h20, 64'h4);

    // R8 completion on empty queue: words drained with no marker
    ready_mode = 1;
    wr(8'h08, (64'd1 << 12) | (64'd4 << 7));
    push(32'hF000_0001, 3'd4, 1);
    push(32'hF000_0002, 3'd4, 1);
    repeat (4) @(posedge clk);
    rd(8'h10, v); chk("R5 credits restored after pops", {55'd0, v[8:0]}, 64'(DEPTH));
    wr(8'h08, (64'd1 << 13) | (64'd1 << 12) | (64'd4 << 7));
    wait_start_low("R8 empty completion closes session");
    rd(8'h20, v); chk("R8 no error on empty completion", v, 64'd0);

    // R2 reset handshake mid-session
    ready_mode = 0;
    wr(8'h08, (64'd1 << 12) | (64'd7 << 7));
    push(32'h7000_0001, 3'd7, 0);
    push(32'h7000_0002, 3'd7, 0);
    wr(8'h08, 64'd1 | (64'd7 << 7));
    rd(8'h08, v); chk("R2 ack raised", {63'd0, v[4]}, 64'd1);
    chk("R2 session abandoned", {63'd0, v[12]}, 64'd0);
    rd(8'h10, v); chk("R11 reset state", {61'd0, v[22:20]}, 64'd1);
    rd(8'h08, v); chk("R2 ack still held", {63'd0, v[4]}, 64'd1);
    wr(8'h08, (64'd1 << 12) | (64'd0 << 7) | 64'd1);
    rd(8'h08, v); chk("R2 start ignored during reset", {63'd0, v[12]}, 64'd0);
    wr(8'h08, 64'd0);
    rd(8'h08, v); chk("R2 ctl after release", v, 64'd0);
    rd(8'h10, v); chk("R2 idle with full credits", v, sts(DEPTH, 0, 0, 4'b0010));
    ready_mode = 1;
    repeat (10) @(posedge clk);
    chk("R4 scoreboard drained", 64'(exp_q.size()), 64'd0);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule